// File: doc/BRIEF.md
# Gated SYSREF Channel Generator

One output channel of a clock distribution block. It divides the reference clock by a programmable channel divider. In clock mode it sends the divided clock out continuously. In SYSREF mode it holds its output low and opens it only for bursts of whole divided-clock pulses.

A burst starts on a rising edge of the SYNC pin or of a software request bit. Its length is set by a pulse-count field `m` and by the ratio `n` of a SYSREF timer divider to the channel divider. One extra pulse is added when multislip is set. Instead of counted bursts, the channel can gate its output by level: it toggles for as long as SYNC or the request bit is high.

A configuration check refuses to start any burst when the dividers are not usable. Continuous SYSREF is produced by selecting clock mode, never by the pulse controller.

Top module: `sysref_chan_gen`

## Requirements
- R1: In clock mode (`cfg_mode`=0) with `cfg_ch_div`=D≥2, `ch_out` is periodic with period D cycles. In each period it is high for ceil(D/2) cycles and low for the rest, which gives exactly 50% duty for even D.
- R2: In SYSREF mode (`cfg_mode`=1), `ch_out` is 0 whenever `busy` is 0.
- R3: In counted operation (`cfg_level`=0) with `cfg_multislip`=1, one burst gives exactly (m+1)·n rising edges on `ch_out`, where n = `cfg_tmr_div`/`cfg_ch_div`.
- R4: In counted operation with `cfg_multislip`=0, one burst gives (m+1)·n−1 rising edges, which can be zero.
- R5: A rising edge on `pulse_req` or on `sync_in` starts a burst. Each input passes through two synchroniser flops. `busy` goes high at the third rising clock edge after the input rises. It stays high until the edge after the last counted pulse, and `ch_out` is 0 when it falls.
- R6: Rising edges of either request that arrive while `busy` is high are ignored. A request held high after its burst has ended does not start another burst.
- R7: With `cfg_level`=1, the channel emits whole divided-clock pulses while `sync_in` or `pulse_req` is high. It returns to 0 with `busy` low once both are low.
- R8: `cfg_err` is 1 when `cfg_tmr_div`=0, `cfg_ch_div`<2, or `cfg_tmr_div` is not an exact multiple of `cfg_ch_div`. While it is 1, no burst and no level gating starts.
- R9: With `cfg_tmr_en`=0, a SYSREF-mode channel emits no pulses and `busy` stays 0.
- R10: The burst gate changes only in a cycle where the divided clock is low, so every emitted pulse is a whole high phase.
- R11: Any change of `cfg_mode` aborts a burst at the next clock edge, drops `busy`, and restarts the divider phase. Returning to SYSREF mode leaves the channel idle.
- R12: After reset, `ch_out` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Asynchronous SYNC pin |
| pulse_req | input | 1 | Software pulse-request bit |
| cfg_mode | input | 1 | 0 = continuous clock, 1 = SYSREF gating |
| cfg_ch_div | input | CH_DIV_W | Channel divide value D |
| cfg_tmr_div | input | TMR_DIV_W | SYSREF timer divide value |
| cfg_tmr_en | input | 1 | SYSREF timer enable |
| cfg_pulse_m | input | PCNT_W | Pulse-count field m |
| cfg_multislip | input | 1 | Adds the extra pulse to counted bursts |
| cfg_level | input | 1 | 1 = level-gated, 0 = counted bursts |
| ch_out | output | 1 | Channel output |
| busy | output | 1 | Burst or level gating in progress |
| cfg_err | output | 1 | Divider configuration unusable |

## Verification
`cfg_err` follows its inputs in the same cycle. `busy` rises at the third edge after a request input rises. Pulses begin at the first divider wrap after that edge. `busy` falls one wrap after the last pulse, and a mode change clears the channel at the very next edge.

The bench drives inputs and samples outputs on falling clock edges. The latency check samples `busy` exactly two and three falling edges after a request. Pulse counts are taken over windows longer than the longest burst plus synchroniser delay, and the idle state is checked only after those windows have closed. Clock-mode duty checks use windows that are whole multiples of the period, so they do not depend on phase alignment.

// File: rtl/sysref_pkg.sv
`timescale 1ns/1ps
package sysref_pkg;
    localparam int CH_DIV_W  = 8;
    localparam int TMR_DIV_W = 10;
    localparam int PCNT_W    = 4;
    localparam int LEN_W     = TMR_DIV_W + PCNT_W + 1;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        MODE_CLK    = 1'b0,
        MODE_SYSREF = 1'b1
    } chan_mode_e;

    typedef enum logic {
        BS_IDLE = 1'b0,
        BS_RUN  = 1'b1
    } burst_st_e;
endpackage

// File: rtl/sysref_sync_edge.sv
`timescale 1ns/1ps
module sysref_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              lvl_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            lvl_d <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            lvl_d <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~lvl_d;
endmodule

// File: rtl/sysref_chan_div.sv
`timescale 1ns/1ps
module sysref_chan_div #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [DW-1:0] div,
    output logic          hi,
    output logic          wrap
);
    logic [DW-1:0] ph;
    logic [DW-1:0] hi_cnt;
    logic          valid;

    assign valid  = (div >= DW'(2));
    assign hi_cnt = div - (div >> 1);
    assign wrap   = valid && (ph >= div - DW'(1));
    assign hi     = valid && (ph < hi_cnt);

    always_ff @(posedge clk) begin
        if (rst || restart || !valid) ph <= '0;
        else if (wrap)                ph <= '0;
        else                          ph <= ph + DW'(1);
    end
endmodule

// File: rtl/sysref_cfg_calc.sv
`timescale 1ns/1ps
module sysref_cfg_calc #(
    parameter int DW = 8,
    parameter int TW = 10,
    parameter int MW = 4,
    localparam int LW = TW + MW + 1
) (
    input  logic [DW-1:0] ch_div,
    input  logic [TW-1:0] tmr_div,
    input  logic [MW-1:0] pulse_m,
    input  logic          multislip,
    output logic          err,
    output logic [LW-1:0] len
);
    logic [TW-1:0] d_ext;
    logic [TW-1:0] ratio;
    logic [TW-1:0] rem;
    logic [LW-1:0] prod;

    assign d_ext = TW'(ch_div);

    always_comb begin
        if (d_ext == '0) begin
            ratio = '0;
            rem   = '0;
        end else begin
            ratio = tmr_div / d_ext;
            rem   = tmr_div % d_ext;
        end
        prod = LW'(ratio) * (LW'(pulse_m) + LW'(1));
        len  = multislip ? prod : prod - LW'(1);
        err  = (tmr_div == '0) || (ch_div < DW'(2)) || (rem != '0);
    end
endmodule

// File: rtl/sysref_burst_ctl.sv
`timescale 1ns/1ps
module sysref_burst_ctl
    import sysref_pkg::*;
#(
    parameter int LW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          enable,
    input  logic          level,
    input  logic          wrap,
    input  logic          trig,
    input  logic          lvl_on,
    input  logic [LW-1:0] len,
    output logic          gate,
    output logic          busy,
    output logic          in_burst,
    output logic [LW-1:0] left
);
    burst_st_e st;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st   <= BS_IDLE;
            gate <= 1'b0;
            left <= '0;
        end else if (!enable) begin
            st <= BS_IDLE;
            if (wrap) gate <= 1'b0;
        end else if (level) begin
            st <= BS_IDLE;
            if (wrap) gate <= lvl_on;
        end else begin
            unique case (st)
                BS_IDLE: begin
                    if (wrap) gate <= 1'b0;
                    if (trig) begin
                        st   <= BS_RUN;
                        left <= len;
                    end
                end
                BS_RUN: begin
                    if (wrap) begin
                        if (left != '0) begin
                            gate <= 1'b1;
                            left <= left - LW'(1);
                        end else begin
                            gate <= 1'b0;
                            st   <= BS_IDLE;
                        end
                    end
                end
                default: st <= BS_IDLE;
            endcase
        end
    end

    assign in_burst = (st == BS_RUN);
    assign busy     = in_burst | gate;
endmodule

// File: rtl/sysref_chan_gen.sv
`timescale 1ns/1ps
module sysref_chan_gen
    import sysref_pkg::*;
#(
    parameter int CH_DIV_W  = sysref_pkg::CH_DIV_W,
    parameter int TMR_DIV_W = sysref_pkg::TMR_DIV_W,
    parameter int PCNT_W    = sysref_pkg::PCNT_W,
    localparam int LW       = TMR_DIV_W + PCNT_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sync_in,
    input  logic                 pulse_req,
    input  logic                 cfg_mode,
    input  logic [CH_DIV_W-1:0]  cfg_ch_div,
    input  logic [TMR_DIV_W-1:0] cfg_tmr_div,
    input  logic                 cfg_tmr_en,
    input  logic [PCNT_W-1:0]    cfg_pulse_m,
    input  logic                 cfg_multislip,
    input  logic                 cfg_level,
    output logic                 ch_out,
    output logic                 busy,
    output logic                 cfg_err
);
    chan_mode_e    mode_q;
    chan_mode_e    mode_in;
    logic          clr;
    logic          div_hi;
    logic          wrap;
    logic          gate;
    logic          in_burst;
    logic [LW-1:0] left_cnt;
    logic [LW-1:0] burst_len;
    logic [1:0]    raw_in;
    logic [1:0]    in_lvl;
    logic [1:0]    in_rise;
    logic          trig;
    logic          lvl_on;
    logic          enable;

    assign mode_in = chan_mode_e'(cfg_mode);
    assign clr     = (mode_in != mode_q);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_CLK;
        else     mode_q <= mode_in;
    end

    assign raw_in = {pulse_req, sync_in};

    for (genvar g = 0; g < 2; g++) begin : g_req
        sysref_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_in[g]),
            .lvl  (in_lvl[g]),
            .rise (in_rise[g])
        );
    end

    assign trig   = |in_rise;
    assign lvl_on = |in_lvl;

    sysref_chan_div #(.DW(CH_DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (clr),
        .div     (cfg_ch_div),
        .hi      (div_hi),
        .wrap    (wrap)
    );

    sysref_cfg_calc #(.DW(CH_DIV_W), .TW(TMR_DIV_W), .MW(PCNT_W)) u_cfg (
        .ch_div    (cfg_ch_div),
        .tmr_div   (cfg_tmr_div),
        .pulse_m   (cfg_pulse_m),
        .multislip (cfg_multislip),
        .err       (cfg_err),
        .len       (burst_len)
    );

    assign enable = (mode_in == MODE_SYSREF) && cfg_tmr_en && !cfg_err;

    sysref_burst_ctl #(.LW(LW)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .clear    (clr),
        .enable   (enable),
        .level    (cfg_level),
        .wrap     (wrap),
        .trig     (trig),
        .lvl_on   (lvl_on),
        .len      (burst_len),
        .gate     (gate),
        .busy     (busy),
        .in_burst (in_burst),
        .left     (left_cnt)
    );

    assign ch_out = div_hi && ((mode_in == MODE_CLK) || gate);
endmodule

// File: rtl/sysref_chan_chk.sv
`timescale 1ns/1ps
module sysref_chan_chk #(
    parameter int LW = sysref_pkg::LEN_W
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_mode,
    input logic          cfg_tmr_en,
    input logic          cfg_err,
    input logic          busy,
    input logic          ch_out,
    input logic          gate,
    input logic          clr,
    input logic          div_hi,
    input logic          in_burst,
    input logic [LW-1:0] left
);
    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && !busy) |-> !ch_out);

    // R5
    busy_fall_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !ch_out);

    // R6
    no_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (in_burst && !clr) |=> (left <= $past(left)));

    // R8
    err_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && !busy) |=> !busy);

    // R9
    tmr_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_tmr_en && !busy) |=> !busy);

    // R10
    gate_low_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ((gate != $past(gate)) && !$past(clr)) |-> !$past(div_hi));

    // R11
    mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !busy);
endmodule

bind sysref_chan_gen sysref_chan_chk #(.LW(sysref_pkg::LEN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_mode   (cfg_mode),
    .cfg_tmr_en (cfg_tmr_en),
    .cfg_err    (cfg_err),
    .busy       (busy),
    .ch_out     (ch_out),
    .gate       (gate),
    .clr        (clr),
    .div_hi     (div_hi),
    .in_burst   (in_burst),
    .left       (left_cnt)
);

// File: tb/test_sysref_chan_gen.sv
`timescale 1ns/1ps
module test_sysref_chan_gen;
    localparam int DW = 8;
    localparam int TW = 10;
    localparam int MW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_in = 1'b0;
    logic          pulse_req = 1'b0;
    logic          cfg_mode = 1'b1;
    logic [DW-1:0] cfg_ch_div = 8'd2;
    logic [TW-1:0] cfg_tmr_div = 10'd4;
    logic          cfg_tmr_en = 1'b1;
    logic [MW-1:0] cfg_pulse_m = 4'd0;
    logic          cfg_multislip = 1'b1;
    logic          cfg_level = 1'b0;
    logic          ch_out;
    logic          busy;
    logic          cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sysref_chan_gen i_sysref_chan_gen (
        .clk(clk), .rst(rst), .sync_in(sync_in), .pulse_req(pulse_req),
        .cfg_mode(cfg_mode), .cfg_ch_div(cfg_ch_div), .cfg_tmr_div(cfg_tmr_div),
        .cfg_tmr_en(cfg_tmr_en), .cfg_pulse_m(cfg_pulse_m),
        .cfg_multislip(cfg_multislip), .cfg_level(cfg_level),
        .ch_out(ch_out), .busy(busy), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [7:0] d;
        logic [9:0] t;
        logic [3:0] m;
        logic       ms;
        logic       src;
        logic [7:0] exp;
    } vec_t;

    // expected = (m+1)*(t/d) with multislip, minus one without
    localparam vec_t VEC [8] = '{
        '{8'd2, 10'd4,  4'd0, 1'b1, 1'b0, 8'd2},
        '{8'd2, 10'd4,  4'd0, 1'b0, 1'b1, 8'd1},
        '{8'd2, 10'd8,  4'd2, 1'b1, 1'b0, 8'd12},
        '{8'd3, 10'd9,  4'd1, 1'b0, 1'b1, 8'd5},
        '{8'd4, 10'd4,  4'd3, 1'b1, 1'b0, 8'd4},
        '{8'd2, 10'd2,  4'd0, 1'b0, 1'b0, 8'd0},
        '{8'd5, 10'd10, 4'd3, 1'b0, 1'b1, 8'd7},
        '{8'd2, 10'd6,  4'd1, 1'b1, 1'b1, 8'd6}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_win(input int win, output int pulses, output int highs, output bit saw_busy);
        bit prev;
        prev = ch_out;
        pulses = 0; highs = 0; saw_busy = 1'b0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (ch_out && !prev) pulses++;
            if (ch_out) highs++;
            if (busy) saw_busy = 1'b1;
            prev = ch_out;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        tick(150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int p, h;
        bit sb;
        tick(5);
        rst = 1'b0;
        tick(1);
        // R12: reset state
        check(ch_out == 1'b0, "R12 ch_out after reset", ch_out, 0);
        check(busy == 1'b0, "R12 busy after reset", busy, 0);
        check(cfg_err == 1'b0, "R8 no error on valid cfg", cfg_err, 0);
        tick(4);

        // R2: idle SYSREF channel stays low
        count_win(20, p, h, sb);
        check(h == 0, "R2 idle output low", h, 0);

        // R3/R4 table of counted bursts from both request sources
        foreach (VEC[k]) begin
            cfg_ch_div = VEC[k].d; cfg_tmr_div = VEC[k].t;
            cfg_pulse_m = VEC[k].m; cfg_multislip = VEC[k].ms;
            tick(3);
            if (VEC[k].src) sync_in = 1'b1; else pulse_req = 1'b1;
            count_win(80, p, h, sb);
            sync_in = 1'b0; pulse_req = 1'b0;
            check(p == int'(VEC[k].exp), VEC[k].ms ? "R3 burst pulse count" : "R4 burst pulse count", p, VEC[k].exp);
            check(sb, "R5 busy seen during burst", sb, 1);
            check(!busy && !ch_out, "R5 idle after burst", {busy, ch_out}, 0);
            tick(4);
        end

        // R5: busy latency of three edges
        cfg_ch_div = 8'd2; cfg_tmr_div = 10'd8; cfg_pulse_m = 4'd2; cfg_multislip = 1'b1;
        tick(2);
        pulse_req = 1'b1;
        tick(2);
        check(busy == 1'b0, "R5 busy not yet after two edges", busy, 0);
        tick(1);
        check(busy == 1'b1, "R5 busy at third edge", busy, 1);
        tick(40);
        pulse_req = 1'b0;
        tick(4);

        // R6: second request inside a burst ignored, held level does not retrigger
        pulse_req = 1'b1;
        p = 0;
        begin
            bit prev;
            prev = ch_out;
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                if (i == 8) pulse_req = 1'b0;
                if (i == 10) pulse_req = 1'b1;
                if (i == 12) sync_in = 1'b1;
                if (ch_out && !prev) p++;
                prev = ch_out;
            end
        end
        check(p == 12, "R6 requests during burst ignored", p, 12);
        count_win(30, p, h, sb);
        check(p == 0 && !sb, "R6 held request no retrigger", p, 0);
        pulse_req = 1'b0; sync_in = 1'b0;
        tick(4);

        // R11: mode change aborts the burst
        pulse_req = 1'b1;
        tick(10);
        check(busy == 1'b1, "R11 burst running before mode change", busy, 1);
        cfg_mode = 1'b0;
        tick(1);
        cfg_mode = 1'b1;
        tick(1);
        check(busy == 1'b0, "R11 busy cleared by mode change", busy, 0);
        count_win(40, p, h, sb);
        check(p == 0 && !sb, "R11 channel idle after return", p, 0);
        pulse_req = 1'b0;
        tick(4);

        // R7: level gating from sync_in and from pulse_req
        cfg_level = 1'b1;
        sync_in = 1'b1;
        count_win(20, p, h, sb);
        sync_in = 1'b0;
        check(p >= 9 && p <= 11, "R7 level pulses from sync", p, 10);
        tick(8);
        count_win(10, p, h, sb);
        check(h == 0 && !sb, "R7 level stop returns low", h, 0);
        pulse_req = 1'b1;
        count_win(12, p, h, sb);
        pulse_req = 1'b0;
        check(p >= 4 && p <= 7, "R7 level pulses from request", p, 5);
        tick(8);
        check(!busy && !ch_out, "R7 idle after request low", busy, 0);
        cfg_level = 1'b0;
        tick(4);

        // R9: timer disabled
        cfg_tmr_en = 1'b0;
        pulse_req = 1'b1;
        count_win(40, p, h, sb);
        pulse_req = 1'b0;
        check(p == 0 && !sb, "R9 no pulses with timer off", p, 0);
        cfg_tmr_en = 1'b1;
        tick(4);

        // R8: unusable divider settings
        cfg_ch_div = 8'd4; cfg_tmr_div = 10'd6;
        tick(1);
        check(cfg_err == 1'b1, "R8 non-multiple flagged", cfg_err, 1);
        pulse_req = 1'b1;
        count_win(40, p, h, sb);
        pulse_req = 1'b0;
        check(p == 0 && !sb, "R8 no burst on error", p, 0);
        cfg_ch_div = 8'd2; cfg_tmr_div = 10'd0;
        tick(1);
        check(cfg_err == 1'b1, "R8 zero timer flagged", cfg_err, 1);
        cfg_ch_div = 8'd1; cfg_tmr_div = 10'd4;
        tick(1);
        check(cfg_err == 1'b1, "R8 divider below two flagged", cfg_err, 1);
        cfg_level = 1'b1;
        sync_in = 1'b1;
        cfg_ch_div = 8'd0;
        count_win(20, p, h, sb);
        sync_in = 1'b0;
        check(h == 0 && !sb, "R8 level gating refused on error", h, 0);
        cfg_level = 1'b0;
        tick(4);

        // R1: clock mode duty over whole periods
        cfg_mode = 1'b0;
        cfg_ch_div = 8'd4;
        tick(6);
        count_win(16, p, h, sb);
        check(h == 8 && p == 4, "R1 divide by 4 highs", h, 8);
        cfg_ch_div = 8'd3;
        tick(6);
        count_win(12, p, h, sb);
        check(h == 8 && p == 4, "R1 divide by 3 highs", h, 8);
        cfg_ch_div = 8'd6;
        tick(6);
        count_win(24, p, h, sb);
        check(h == 12 && p == 4, "R1 divide by 6 highs", h, 12);

        summary();
    end
endmodule